// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory. Its read path is pipelined and its write data arrives one cycle after the address. On each rising clock edge it captures an address, a read/write select, a chip select and one write enable per 9-bit byte lane. A write command's data word is taken one edge later and parked in a write buffer. That buffer drains into the storage array only when the next write command reaches its data phase. A read whose address matches the parked write sees the parked bytes merged over the stored word, so the memory always behaves as if every write had already landed.

Read data leaves through an output register. The output stays driven for one extra cycle after the read stream ends, and then releases. The high-impedance state is modelled as a `rvalid` flag next to the data bus. An output enable gates that flag without waiting for a clock edge. A sleep input, sampled on the edge, turns any command presented with it into a no-op, and the stored contents and the parked write are kept.

Top module: `lw_sram`

## Requirements
- R1: While reset is low, and on the first edges after it is released, `rvalid` is 0.
- R2: A read captured on edge n shows its word on `rdata` with `rvalid` high after edge n+1. The word is not visible after edge n alone.
- R3: The data word of a write is the `wdata` value sampled on the edge after the write command. The `wdata` value present on the command edge itself is ignored.
- R4: Byte lane i covers bits [9i+8:9i] and is written only when `bwe[i]` is 1. A lane with `bwe[i]` at 0 keeps its old content, including when all enables are 0.
- R5: A read of the address held in the write buffer returns the buffered bytes in the enabled lanes and the stored bytes in the other lanes. This also holds for a read issued in the very next cycle after the write.
- R6: A buffered write survives any number of intervening reads and idle cycles. Successive writes commit in issue order, so the last write to an address wins.
- R7: After the last read, the first non-read cycle keeps `rvalid` high with `rdata` unchanged for one extra cycle. `rvalid` then falls on the following edge.
- R8: With `oe` low, `rvalid` is 0 and `rdata` is 0 at once, with no clock edge needed. Raising `oe` restores the registered output at once.
- R9: A command sampled while `sleep` is 1 is ignored: a write changes no stored data and a read produces no output. Stored contents are retained.
- R10: A cycle with `sel` at 0 performs no access, whatever `we` and `bwe` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all capture and state |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| sel | input | 1 | Chip select; 1 accepts a command this edge |
| we | input | 1 | 1 = write command, 0 = read command |
| addr | input | ADDR_W | Word address of the command |
| bwe | input | WORD_W/9 | Per-lane write enables, sampled with the command |
| wdata | input | WORD_W | Write data, sampled one edge after its command |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | 1 turns the command on this edge into a no-op |
| rdata | output | WORD_W | Read data; 0 while not driven |
| rvalid | output | 1 | 1 while the output is driven |

## Verification
A write buffer that loses its contents, or commits out of order, shows up as a stale word on the next read of that address. For an immediate re-read this is visible two edges after the read command. A wrong forwarding compare or lane mask corrupts exactly the lanes involved in the first read after the write. A fault in the deselect state machine moves the falling edge of `rvalid` one cycle early or late, and the bench sees it on the second idle cycle after a read burst. A sleep or select gate that leaks lets a suppressed write appear on the next read of the same address.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

   // width of one byte lane
   localparam int unsigned LANE_W = 9;

   // operation held in the input register for the current cycle
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

endpackage

// File: rtl/lw_sram_in_reg.sv
module lw_sram_in_reg
   import lw_sram_pkg::*;
#(
   parameter int unsigned AW    = 6,
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             we,
   input  logic             sleep,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] bwe,
   output op_e              op_q,
   output logic [AW-1:0]    addr_q,
   output logic [LANES-1:0] bwe_q
);

   logic accept;

   // sleep or a deselected cycle turns the edge into a no-op
   assign accept = sel && !sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
         bwe_q  <= '0;
      end else begin
         if (!accept) begin
            op_q <= OP_IDLE;
         end else if (we) begin
            op_q <= OP_WRITE;
         end else begin
            op_q <= OP_READ;
         end
         if (accept) begin
            addr_q <= addr;
            bwe_q  <= bwe;
         end
      end
   end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
   import lw_sram_pkg::*;
#(
   parameter int unsigned AW    = 6,
   parameter int unsigned DW    = 36,
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              in_op,
   input  logic [AW-1:0]    in_addr,
   input  logic [LANES-1:0] in_bwe,
   input  logic [DW-1:0]    wdata,
   input  logic [DW-1:0]    arr_word,
   output logic             pend_valid,
   output logic [AW-1:0]    pend_addr,
   output logic [LANES-1:0] pend_bwe,
   output logic [DW-1:0]    pend_data,
   output logic             commit_en,
   output logic [DW-1:0]    fwd_word
);

   logic hit;

   // the parked write drains while the next write takes its place
   assign commit_en = (in_op == OP_WRITE) && pend_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_bwe   <= '0;
         pend_data  <= '0;
      end else if (in_op == OP_WRITE) begin
         pend_valid <= 1'b1;
         pend_addr  <= in_addr;
         pend_bwe   <= in_bwe;
         pend_data  <= wdata;
      end
   end

   assign hit = pend_valid && (pend_addr == in_addr);

   for (genvar l = 0; l < LANES; l++) begin : g_fwd
      assign fwd_word[l*LANE_W +: LANE_W] = (hit && pend_bwe[l])
                                          ? pend_data[l*LANE_W +: LANE_W]
                                          : arr_word[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
   import lw_sram_pkg::*;
#(
   parameter int unsigned AW    = 6,
   parameter int unsigned DW    = 36,
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [LANES-1:0] wr_be,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data
);

   localparam int unsigned DEPTH = 1 << AW;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_be[l]) begin
            cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
         end
      end

      assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
   end

endmodule

// File: rtl/lw_sram_out.sv
module lw_sram_out #(
   parameter int unsigned DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic          oe,
   output logic          out_drv,
   output logic          out_tail,
   output logic [DW-1:0] out_data,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);

   // load: a read is in its second stage; otherwise run the two-step release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_drv  <= 1'b0;
         out_tail <= 1'b0;
         out_data <= '0;
      end else if (load) begin
         out_drv  <= 1'b1;
         out_tail <= 1'b0;
         out_data <= din;
      end else if (out_drv && !out_tail) begin
         out_tail <= 1'b1;
      end else begin
         out_drv  <= 1'b0;
         out_tail <= 1'b0;
      end
   end

   assign rvalid = out_drv && oe;
   assign rdata  = rvalid ? out_data : '0;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned WORD_W = 36
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [WORD_W/LANE_W-1:0] bwe,
   input  logic [WORD_W-1:0]        wdata,
   input  logic                     oe,
   input  logic                     sleep,
   output logic [WORD_W-1:0]        rdata,
   output logic                     rvalid
);

   localparam int unsigned LANES = WORD_W / LANE_W;

   if (WORD_W != 18 && WORD_W != 36) begin : g_bad_word
      $error("lw_sram: WORD_W must be 18 or 36");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("lw_sram: ADDR_W must lie in 1..10");
   end

   op_e               in_op;
   logic [ADDR_W-1:0] in_addr;
   logic [LANES-1:0]  in_bwe;
   logic              in_rd;
   logic              in_act;

   logic              pend_valid;
   logic [ADDR_W-1:0] pend_addr;
   logic [LANES-1:0]  pend_bwe;
   logic [WORD_W-1:0] pend_data;
   logic              commit_en;
   logic [WORD_W-1:0] fwd_word;
   logic [WORD_W-1:0] arr_word;

   logic              out_drv;
   logic              out_tail;
   logic [WORD_W-1:0] out_data;

   lw_sram_in_reg #(.AW(ADDR_W), .LANES(LANES)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .we     (we),
      .sleep  (sleep),
      .addr   (addr),
      .bwe    (bwe),
      .op_q   (in_op),
      .addr_q (in_addr),
      .bwe_q  (in_bwe)
   );

   assign in_rd  = (in_op == OP_READ);
   assign in_act = (in_op != OP_IDLE);

   lw_sram_wbuf #(.AW(ADDR_W), .DW(WORD_W), .LANES(LANES)) u_wbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_op      (in_op),
      .in_addr    (in_addr),
      .in_bwe     (in_bwe),
      .wdata      (wdata),
      .arr_word   (arr_word),
      .pend_valid (pend_valid),
      .pend_addr  (pend_addr),
      .pend_bwe   (pend_bwe),
      .pend_data  (pend_data),
      .commit_en  (commit_en),
      .fwd_word   (fwd_word)
   );

   lw_sram_array #(.AW(ADDR_W), .DW(WORD_W), .LANES(LANES)) u_array (
      .clk     (clk),
      .wr_en   (commit_en),
      .wr_addr (pend_addr),
      .wr_be   (pend_bwe),
      .wr_data (pend_data),
      .rd_addr (in_addr),
      .rd_data (arr_word)
   );

   lw_sram_out #(.DW(WORD_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (in_rd),
      .din      (fwd_word),
      .oe       (oe),
      .out_drv  (out_drv),
      .out_tail (out_tail),
      .out_data (out_data),
      .rdata    (rdata),
      .rvalid   (rvalid)
   );

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
   parameter int unsigned AW    = 6,
   parameter int unsigned DW    = 36,
   parameter int unsigned LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel,
   input logic             we,
   input logic             sleep,
   input logic             rvalid,
   input logic             in_rd,
   input logic             in_act,
   input logic [AW-1:0]    in_addr,
   input logic             pend_valid,
   input logic [AW-1:0]    pend_addr,
   input logic [LANES-1:0] pend_bwe,
   input logic [DW-1:0]    pend_data,
   input logic             out_drv,
   input logic             out_tail,
   input logic [DW-1:0]    out_data
);

   // R1: output released while in reset
   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !rvalid);

   // R2: accepted read drives the output register two edges later
   p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !we && !sleep) |=> ##1 out_drv);

   // R5: full-lane hit returns the buffered word
   p_fwd_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rd && pend_valid && pend_addr == in_addr && (&pend_bwe))
      |=> (out_data == $past(pend_data)));

   // R6: a parked write is never dropped
   p_pend_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |=> pend_valid);

   // R7: the driver never releases after a single driven cycle
   p_dcd_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_drv) |-> $past(out_drv, 2));

   // R7: data held through the extra driven cycle
   p_tail_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_tail |-> $stable(out_data));

   // R9: a sleeping edge leaves no command in the input register
   p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !in_act);

endmodule

bind lw_sram lw_sram_chk #(.AW(ADDR_W), .DW(WORD_W), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel        (sel),
   .we         (we),
   .sleep      (sleep),
   .rvalid     (rvalid),
   .in_rd      (in_rd),
   .in_act     (in_act),
   .in_addr    (in_addr),
   .pend_valid (pend_valid),
   .pend_addr  (pend_addr),
   .pend_bwe   (pend_bwe),
   .pend_data  (pend_data),
   .out_drv    (out_drv),
   .out_tail   (out_tail),
   .out_data   (out_data)
);

// File: tb/lw_sram_tb_top.sv
`timescale 1ns/1ps
module lw_sram_tb_top;

   localparam int unsigned AW = 6;
   localparam int unsigned W  = 36;
   localparam int unsigned L  = W / 9;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel   = 1'b0;
   logic          we    = 1'b0;
   logic [AW-1:0] addr  = '0;
   logic [L-1:0]  bwe   = '0;
   logic [W-1:0]  wdata = '0;
   logic          oe    = 1'b1;
   logic          sleep = 1'b0;
   logic [W-1:0]  rdata;
   logic          rvalid;

   lw_sram #(.ADDR_W(AW), .WORD_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .bwe(bwe),
      .wdata(wdata), .oe(oe), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
   );

   always #2.5 clk = ~clk;

   int edge_no = 0;
   always @(posedge clk) edge_no <= edge_no + 1;

   logic [W-1:0] model [1 << AW];
   int           due_q [$];
   logic [W-1:0] dat_q [$];
   string        tag_q [$];

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   bit carry_v = 1'b0;
   logic [W-1:0] carry_d = '0;

   function automatic logic [W-1:0] rnd();
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      return r[W-1:0];
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one command per cycle, late data carried to the next cycle
   task automatic op(input bit s, input bit w, input int unsigned a, input logic [L-1:0] be,
                     input logic [W-1:0] d, input bit slp, input string tag);
      @(negedge clk);
      sel   = s;
      we    = w;
      addr  = a[AW-1:0];
      bwe   = be;
      sleep = slp;
      wdata = carry_v ? carry_d : rnd();
      carry_v = s && w && !slp;
      carry_d = d;
      if (s && !slp) begin
         if (w) begin
            for (int i = 0; i < int'(L); i++)
               if (be[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
         end else begin
            due_q.push_back(edge_no + 2);
            dat_q.push_back(model[a]);
            tag_q.push_back(tag);
         end
      end
   endtask

   task automatic wr(input int unsigned a, input logic [L-1:0] be, input logic [W-1:0] d);
      op(1'b1, 1'b1, a, be, d, 1'b0, "");
   endtask

   task automatic rd(input int unsigned a, input string tag);
      op(1'b1, 1'b0, a, '0, '0, 1'b0, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 1'b0, 0, '0, '0, 1'b0, "");
   endtask

   // monitor: compares scoreboard entries in the cycle they fall due
   always @(negedge clk) begin
      while (due_q.size() > 0 && due_q[0] <= edge_no) begin
         check({tag_q[0], " rvalid"}, W'(rvalid), W'(1));
         check(tag_q[0], rdata, dat_q[0]);
         void'(due_q.pop_front());
         void'(dat_q.pop_front());
         void'(tag_q.pop_front());
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) model[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 in reset", W'(rvalid), W'(0));
      rst_n = 1'b1;
      // preload every word so no read touches an unwritten cell
      for (int a = 0; a < (1 << AW); a++) wr(a, '1, rnd());
      idle(2);
      check("R1 after release", W'(rvalid), W'(0));

      // R3: back-to-back writes with junk on the address cycle, then readback
      for (int a = 0; a < 12; a++) wr(a, '1, rnd());
      idle(1);
      for (int a = 0; a < 12; a++) rd(a, "R3 readback");
      idle(4);

      // R2: lone read, output must not appear one edge early
      rd(20, "R2 latency");
      idle(1);
      check("R2 not early", W'(rvalid), W'(0));
      idle(4);

      // R4: partial lane writes and an all-zero enable write
      wr(5, 4'b0101, rnd());
      wr(6, 4'b1000, rnd());
      wr(7, 4'b0000, rnd());
      idle(2);
      rd(5, "R4 lanes 0,2");
      rd(6, "R4 lane 3");
      rd(7, "R4 no lanes");
      idle(4);

      // R5: immediate re-read, full and merged
      wr(9, '1, rnd());
      rd(9, "R5 full hit");
      wr(9, 4'b0010, rnd());
      rd(9, "R5 merged hit");
      wr(8, 4'b1001, rnd());
      idle(1);
      rd(8, "R5 hit after idle");
      idle(4);

      // R6: parked write survives reads; ordering of successive writes
      wr(10, '1, rnd());
      for (int a = 1; a < 5; a++) rd(a, "R6 other");
      idle(3);
      rd(10, "R6 parked");
      wr(11, '1, rnd());
      wr(11, '1, rnd());
      wr(12, 4'b0011, rnd());
      wr(11, 4'b0100, rnd());
      idle(2);
      rd(11, "R6 order");
      rd(12, "R6 next");
      idle(4);

      // R7: dual-cycle release
      begin
         logic [W-1:0] exp;
         exp = model[3];
         rd(3, "R7 data");
         idle(2);
         check("R7 first driven cycle", W'(rvalid), W'(1));
         idle(1);
         check("R7 extra cycle valid", W'(rvalid), W'(1));
         check("R7 extra cycle data", rdata, exp);
         idle(1);
         check("R7 released", W'(rvalid), W'(0));
      end
      idle(3);

      // R8: asynchronous output enable
      rd(4, "R8 data");
      idle(2);
      #1 oe = 1'b0;
      #0.5;
      check("R8 oe low rvalid", W'(rvalid), W'(0));
      check("R8 oe low rdata", rdata, '0);
      #0.5 oe = 1'b1;
      #0.5;
      check("R8 oe restored", W'(rvalid), W'(1));
      idle(4);

      // R9: sleep suppresses both writes and reads
      op(1'b1, 1'b1, 15, '1, rnd(), 1'b1, "");
      idle(2);
      rd(15, "R9 write ignored");
      idle(4);
      op(1'b1, 1'b0, 16, '0, '0, 1'b1, "");
      idle(2);
      check("R9 read ignored", W'(rvalid), W'(0));
      idle(1);

      // R10: deselected write has no effect
      op(1'b0, 1'b1, 17, '1, rnd(), 1'b0, "");
      idle(2);
      rd(17, "R10 deselected");
      idle(4);
      check("R6 scoreboard drained", W'(due_q.size()), W'(0));

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule